// File: doc/BRIEF.md
# Shared-Adder Fetch Program Counter

This block produces the fetch address for a pipelined processor front end. One 32-bit adder does all of the address arithmetic. Its first operand is always the current program counter. Its second operand comes from a narrow two-way select: either the constant four for sequential fetch, or a sign-extended branch displacement scaled to words. Because only one sum exists per cycle, a taken branch costs two fetch slots. The first is the delay slot, which executes normally. The second is a fetch that the block marks invalid on its annul output.

A decode stage raises the taken strobe, together with a 16-bit word displacement, in the cycle where the delay-slot address is on the fetch output. In the following cycle the register keeps that address and annul is raised. During that cycle the adder forms the delay-slot address plus the scaled displacement. The cycle after that fetches the target. A stall freezes the address and any pending annul.

Top module: `pc_fetch_unit`

## Requirements
- R1: While reset is asserted, and right after it is released, the fetch address equals the parameter RESET_VEC and annul is low.
- R2: In each clock cycle without stall, taken strobe or pending annul, the fetch address grows by 4, wrapping modulo 2^32.
- R3: A taken strobe in an unstalled cycle whose fetch address is D, with annul low, causes two things. The next fetch slot repeats address D with annul high. The slot after that fetches D plus four times the displacement.
- R4: The 16-bit displacement is a two's-complement word count. Bit 15 set gives a backward target, for example 0xFFFF gives D-4 and 0x8000 gives D-131072.
- R5: Annul is high for exactly one unstalled fetch slot per taken branch. A new strobe on the first target slot starts a fresh branch.
- R6: While stall is high, the fetch address and annul keep their values, and a taken strobe has no effect.
- R7: A taken strobe raised during the annulled slot is ignored. The target still comes from the displacement latched with the original strobe, and no second annulled slot follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous active-high reset |
| stall | input | 1 | Freezes the address and the pending annul |
| branchTaken | input | 1 | Taken-branch strobe, applied while the delay slot is fetched |
| branchDisp | input | 16 | Signed word displacement, relative to the delay-slot address |
| fetchPc | output | 32 | Current fetch address |
| annul | output | 1 | Marks the current fetch slot as invalid |

## Verification
Every result of this block becomes visible one clock edge after the input that causes it. A sequential step, the repeated delay-slot address with annul high, and a held value under stall all appear at the next edge. The branch target appears at the second unstalled edge after the strobe. The bench drives inputs after a falling edge and advances its behavioural model at the rising edge. It compares both outputs at the next falling edge, so each result is checked in the exact cycle it is due. Stall cycles move the target later by one cycle each, and the model counts them the same way.

// File: rtl/pc_unit_pkg.sv
package pc_unit_pkg;
  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic advance;   // write the adder result into the PC
    logic useDisp;   // adder operand B is the scaled displacement
    logic loadDisp;  // capture the displacement input
  } pcCtl_t;
endpackage

// File: rtl/pc_ctrl.sv
module pc_ctrl
  import pc_unit_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   stall,
  input  logic   branchTaken,
  output pcCtl_t ctl,
  output logic   annul
);
  logic pendQ;

  always_comb begin
    ctl = '0;
    if (!stall) begin
      if (pendQ) begin
        ctl.advance = 1'b1;
        ctl.useDisp = 1'b1;
      end else if (branchTaken) begin
        ctl.loadDisp = 1'b1;
      end else begin
        ctl.advance = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)         pendQ <= 1'b0;
    else if (!stall) pendQ <= pendQ ? 1'b0 : branchTaken;
  end

  assign annul = pendQ;

  AST_BRANCH_ARMS_ANNUL: assert property (@(posedge clk) disable iff (rst)
    (!stall && !annul && branchTaken) |=> annul); // R3
  AST_ANNUL_ONE_SLOT: assert property (@(posedge clk) disable iff (rst)
    (annul && !stall) |=> !annul); // R5
  AST_STALL_KEEPS_ANNUL: assert property (@(posedge clk) disable iff (rst)
    stall |=> annul == $past(annul)); // R6
  AST_STROBE_IN_ANNUL_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (annul && !stall && branchTaken) |=> !annul); // R7
endmodule

// File: rtl/pc_datapath.sv
module pc_datapath
  import pc_unit_pkg::*;
#(
  parameter int          PC_W      = 32,
  parameter int          DISP_W    = 16,
  parameter logic [31:0] RESET_VEC = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  pcCtl_t            ctl,
  input  logic [DISP_W-1:0] dispIn,
  output logic [PC_W-1:0]   pcOut
);
  localparam int            EXT_W = PC_W - DISP_W - 2;
  localparam logic [PC_W-1:0] STEP  = PC_W'(4);
  localparam logic [PC_W-1:0] VEC   = PC_W'(RESET_VEC);

  logic [PC_W-1:0]   pcQ;
  logic [DISP_W-1:0] dispQ;
  logic [PC_W-1:0]   scaledDisp;
  logic [PC_W-1:0]   operandB;
  logic [PC_W-1:0]   sum;

  generate
    if (EXT_W > 0) begin : g_ext
      assign scaledDisp = {{EXT_W{dispQ[DISP_W-1]}}, dispQ, 2'b00};
    end else begin : g_trunc
      assign scaledDisp = PC_W'({dispQ, 2'b00});
    end
  endgenerate

  assign operandB = ctl.useDisp ? scaledDisp : STEP;
  assign sum      = pcQ + operandB;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      pcQ   <= VEC;
      dispQ <= '0;
    end else begin
      if (ctl.advance)  pcQ   <= sum;
      if (ctl.loadDisp) dispQ <= dispIn;
    end
  end

  assign pcOut = pcQ;

  AST_HOLD_WITHOUT_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    !ctl.advance |=> $stable(pcQ)); // R6
  AST_STEP_FOUR: assert property (@(posedge clk) disable iff (rst)
    (ctl.advance && !ctl.useDisp) |=> pcQ == $past(pcQ) + STEP); // R2
  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (rst)
    pcQ[1:0] == VEC[1:0]); // R4
endmodule

// File: rtl/pc_fetch_unit.sv
module pc_fetch_unit
  import pc_unit_pkg::*;
#(
  parameter int          PC_W      = 32,
  parameter int          DISP_W    = 16,
  parameter logic [31:0] RESET_VEC = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall,
  input  logic              branchTaken,
  input  logic [DISP_W-1:0] branchDisp,
  output logic [PC_W-1:0]   fetchPc,
  output logic              annul
);
  pcCtl_t ctl;

  pc_ctrl u_ctrl (
    .clk(clk), .rst(rst), .stall(stall), .branchTaken(branchTaken),
    .ctl(ctl), .annul(annul)
  );

  pc_datapath #(.PC_W(PC_W), .DISP_W(DISP_W), .RESET_VEC(RESET_VEC)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .dispIn(branchDisp), .pcOut(fetchPc)
  );

  AST_RESET_STATE: assert property (@(posedge clk)
    $fell(rst) |-> (fetchPc == PC_W'(RESET_VEC) && !annul)); // R1
endmodule

// File: tb/tb_pc_fetch_unit.sv
module tb_pc_fetch_unit;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] VEC        = 32'hFFFF_FFF0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stall = 1'b0;
  logic        branchTaken = 1'b0;
  logic [15:0] branchDisp = '0;
  logic [31:0] fetchPc;
  logic        annul;

  int    nChecks = 0;
  int    nFails  = 0;
  bit    finished = 1'b0;

  logic [31:0] refPc;
  bit          refPend;
  logic [31:0] refTarget[$];

  pc_fetch_unit #(.RESET_VEC(VEC)) dut (
    .clk(clk), .rst(rst), .stall(stall), .branchTaken(branchTaken),
    .branchDisp(branchDisp), .fetchPc(fetchPc), .annul(annul)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic compare(input string req);
    nChecks++;
    if (fetchPc !== refPc || annul !== logic'(refPend)) begin
      nFails++;
      $display("FAIL %s: fetchPc=%h annul=%b expected fetchPc=%h annul=%b",
               req, fetchPc, annul, refPc, refPend);
    end
  endtask

  task automatic step(input bit st, input bit br, input logic [15:0] d, input string req);
    stall = st; branchTaken = br; branchDisp = d;
    @(posedge clk);
    if (!st) begin
      if (refPend) begin
        refPc   = refTarget.pop_front();
        refPend = 1'b0;
      end else if (br) begin
        int off = int'($signed(d));
        refTarget.push_back(refPc + 32'(off * 4));
        refPend = 1'b1;
      end else begin
        refPc = refPc + 32'd4;
      end
    end
    @(negedge clk);
    compare(req);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    nChecks++; nFails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    summary();
  end

  initial begin
    refPc = VEC; refPend = 1'b0;
    @(negedge clk); compare("R1");
    @(negedge clk); rst = 1'b0;
    compare("R1");
    // R2: sequential run across the 32-bit wrap
    for (int i = 0; i < 6; i++) step(0, 0, 16'h0, "R2");
    // R3: forward branch, delay slot then repeated address annulled
    step(0, 1, 16'd16, "R3");
    step(0, 0, 16'h0, "R3");
    step(0, 0, 16'h0, "R2");
    step(0, 0, 16'h0, "R2");
    // R4: negative displacement
    step(0, 1, 16'hFFFF, "R4");
    step(0, 0, 16'h0, "R4");
    step(0, 0, 16'h0, "R4");
    // R6: strobe under stall ignored, PC held
    step(1, 1, 16'd50, "R6");
    step(1, 1, 16'd50, "R6");
    step(0, 0, 16'h0, "R6");
    // R6/R7: stall inside annulled slot, strobe in annulled slot ignored
    step(0, 1, 16'd2, "R3");
    step(1, 0, 16'h0, "R6");
    step(1, 1, 16'd100, "R6");
    step(0, 1, 16'd100, "R7");
    step(0, 0, 16'h0, "R7");
    // R3: zero displacement returns to the delay-slot address
    step(0, 1, 16'h0, "R3");
    step(0, 0, 16'h0, "R3");
    // R5: back-to-back branches, one annul slot each
    step(0, 1, 16'd8, "R5");
    step(0, 0, 16'h0, "R5");
    step(0, 1, 16'd4, "R5");
    step(0, 0, 16'h0, "R5");
    step(0, 0, 16'h0, "R5");
    // R4: most negative displacement
    step(0, 1, 16'h8000, "R4");
    step(0, 0, 16'h0, "R4");
    step(0, 0, 16'h0, "R4");
    step(0, 0, 16'h0, "R2");
    summary();
  end
endmodule